// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Sleep and Enable Gating

This block is an asynchronous serial receiver for multidrop links where many nodes share one line. A frame carries an extra marker bit that tags a character as a node address or as ordinary data. The input is oversampled sixteen times per bit and the line value is taken by majority vote at mid-bit. A shift register builds the character.

Once a character is complete, a gating stage decides whether it goes into the receive buffer. When it does, that stage updates the ready flag, the four error flags and the interrupt. A node that is not being addressed sets its sleep control. It then ignores data characters but still accepts address characters, so software can recognise its own address. The receive-enable control stops transfers into the buffer and stops interrupts, but the shift register keeps assembling characters while it is off.

The bit rate comes from a divider that produces one oversampling tick every `baud_div_i + 1` clocks.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is one low start bit, then 8 data bits LSB first, then one parity bit only when `par_en_i` is 1, then one marker bit (1 = address, 0 = data), then one stop bit. A transferred character shows up on `data_o` and `addr_o` with `rdy_o` set to 1.
- R2: One bit lasts 16*(`baud_div_i`+1) clock cycles, and each bit value is the majority of three samples taken around the middle of the bit.
- R3: When `par_en_i` is 1, `pe_o` is set if the parity of the 8 data bits XOR the parity bit differs from `par_odd_i`. With `par_odd_i`=0 the count of ones must be even, and with `par_odd_i`=1 it must be odd.
- R4: `fe_o` is set when the stop bit is sampled low.
- R5: `brk_o` is set when every bit after the start bit, stop bit included, is sampled low.
- R6: `oe_o` is set when a character is transferred while `rdy_o` is still 1. The buffer then holds the newer character.
- R7: A pulse on `rd_i` clears `rdy_o`, `brk_o`, `fe_o`, `oe_o` and `pe_o`. Reset clears all outputs.
- R8: A character that completes while `rx_en_i` is 0 is not transferred. `data_o` keeps its value, and neither `rdy_o` nor `irq_o` rises.
- R9: `rx_en_i` is looked at when a character completes. A character that was already being received when `rx_en_i` rose is still transferred.
- R10: While `sleep_o` is 1, a data character (marker bit 0) changes neither the buffer, `rdy_o` nor any error flag.
- R11: While `sleep_o` is 1, an address character is transferred normally and `sleep_o` stays 1. `sleep_o` changes only on a `sleep_wr_i` pulse, which loads `sleep_val_i`.
- R12: `irq_o` equals `rdy_o` AND `rx_en_i` as sampled at the previous clock edge. It therefore drops after `rx_en_i` falls while `rdy_o` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial line, idle high |
| baud_div_i | input | DIV_W | Clocks per oversampling tick, minus one |
| par_en_i | input | 1 | Parity bit present in the frame |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rx_en_i | input | 1 | Allow transfer into the buffer and interrupts |
| sleep_wr_i | input | 1 | Write strobe for the sleep control |
| sleep_val_i | input | 1 | Value loaded into sleep on a write |
| rd_i | input | 1 | Buffer read strobe, clears the status flags |
| data_o | output | 8 | Received data byte |
| addr_o | output | 1 | Marker bit of the buffered character |
| rdy_o | output | 1 | Buffer holds an unread character |
| brk_o | output | 1 | Break detected |
| fe_o | output | 1 | Framing error |
| oe_o | output | 1 | Overrun error |
| pe_o | output | 1 | Parity error |
| irq_o | output | 1 | Receive interrupt |
| sleep_o | output | 1 | Current sleep control |

## Verification
A character completes at the vote in the middle of its stop bit. That is about half a bit plus two synchroniser stages and one vote cycle after the stop bit begins, and `data_o`, `rdy_o`, the error flags and `irq_o` update one clock after that. The bench holds the stop bit for a full bit time and then idles for two more bit times before it samples, so every result has settled well before the check. A read strobe or a sleep write takes effect at the next edge, and the bench waits one further negative edge before it checks the outputs.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_HOLD  = 2'd3
  } rx_state_t;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          addr;
    logic          pbit;
    logic          stop;
    logic          all_low;
  } rx_char_t;
endpackage

// File: rtl/mpr_tick.sv
module mpr_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= div_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div_i != '0 && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/mpr_shift.sv
module mpr_shift
  import mpr_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick_i,
  input  logic     rx_i,
  input  logic     par_en_i,
  output logic     done_o,
  output rx_char_t chr_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
  localparam logic [3:0] IDX_PAR = 4'(DW);

  logic [1:0]       sync_q;
  logic             rx_s;
  logic [1:0]       win_q;
  logic             vote;
  rx_state_t        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       idx_q;
  logic [3:0]       idx_stop;
  logic [3:0]       idx_mark;
  logic [DW-1:0]    sh_q;
  logic             pb_q;
  logic             ab_q;
  logic             acc_q;

  assign rx_s     = sync_q[1];
  assign vote     = (win_q[1] & win_q[0]) | (win_q[1] & rx_s) | (win_q[0] & rx_s);
  assign idx_stop = par_en_i ? IDX_PAR + 4'd2 : IDX_PAR + 4'd1;
  assign idx_mark = idx_stop - 4'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      win_q  <= 2'b11;
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pb_q   <= 1'b0;
      ab_q   <= 1'b0;
      acc_q  <= 1'b1;
      done_o <= 1'b0;
      chr_o  <= '0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      done_o <= 1'b0;
      if (tick_i) begin
        win_q <= {win_q[0], rx_s};
        case (st_q)
          ST_IDLE: begin
            if (!rx_s) begin
              st_q  <= ST_START;
              cnt_q <= CNT_W'(1);
              acc_q <= 1'b1;
            end
          end
          ST_START: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == MID && vote) begin
              st_q <= ST_IDLE;
            end else if (cnt_q == LAST) begin
              st_q  <= ST_BITS;
              cnt_q <= '0;
              idx_q <= '0;
            end
          end
          ST_BITS: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == MID) begin
              acc_q <= acc_q & ~vote;
              if (idx_q < IDX_PAR) begin
                sh_q <= {vote, sh_q[DW-1:1]};
              end else if (idx_q == idx_stop) begin
                done_o        <= 1'b1;
                chr_o.data    <= sh_q;
                chr_o.addr    <= ab_q;
                chr_o.pbit    <= pb_q;
                chr_o.stop    <= vote;
                chr_o.all_low <= acc_q & ~vote;
                st_q          <= vote ? ST_IDLE : ST_HOLD;
              end else if (idx_q == idx_mark) begin
                ab_q <= vote;
              end else begin
                pb_q <= vote;
              end
            end
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              idx_q <= idx_q + 4'd1;
            end
          end
          default: begin
            if (rx_s) st_q <= ST_IDLE;
          end
        endcase
      end
    end
  end

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: rtl/mpr_gate.sv
module mpr_gate
  import mpr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          done_i,
  input  rx_char_t      chr_i,
  input  logic          rx_en_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          sleep_wr_i,
  input  logic          sleep_val_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          addr_o,
  output logic          rdy_o,
  output logic          brk_o,
  output logic          fe_o,
  output logic          oe_o,
  output logic          pe_o,
  output logic          irq_o,
  output logic          sleep_o
);
  logic accept;
  logic par_bad;

  assign accept  = done_i && rx_en_i && (!sleep_o || chr_i.addr);
  assign par_bad = par_en_i && ((^chr_i.data ^ chr_i.pbit) != par_odd_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      addr_o  <= 1'b0;
      rdy_o   <= 1'b0;
      brk_o   <= 1'b0;
      fe_o    <= 1'b0;
      oe_o    <= 1'b0;
      pe_o    <= 1'b0;
      irq_o   <= 1'b0;
      sleep_o <= 1'b0;
    end else begin
      if (sleep_wr_i) sleep_o <= sleep_val_i;
      if (accept) begin
        data_o <= chr_i.data;
        addr_o <= chr_i.addr;
        rdy_o  <= 1'b1;
        oe_o   <= (rdy_o | oe_o) & ~rd_i;
        fe_o   <= ~chr_i.stop;
        brk_o  <= chr_i.all_low;
        pe_o   <= par_bad;
      end else if (rd_i) begin
        rdy_o <= 1'b0;
        oe_o  <= 1'b0;
        fe_o  <= 1'b0;
        brk_o <= 1'b0;
        pe_o  <= 1'b0;
      end
      irq_o <= (accept | (rdy_o & ~rd_i)) & rx_en_i;
    end
  end

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && !rx_en_i) |=> ($stable(data_o) && !$rose(rdy_o)));
  // R10
  sleep_filter_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && sleep_o && !chr_i.addr && !rdy_o) |=> !rdy_o);
  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sleep_wr_i |=> $stable(sleep_o));
  // R12
  irq_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> rdy_o);
  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !done_i) |=> (!rdy_o && !fe_o && !oe_o && !pe_o && !brk_o));
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mpr_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic             rx_en_i,
  input  logic             sleep_wr_i,
  input  logic             sleep_val_i,
  input  logic             rd_i,
  output logic [7:0]       data_o,
  output logic             addr_o,
  output logic             rdy_o,
  output logic             brk_o,
  output logic             fe_o,
  output logic             oe_o,
  output logic             pe_o,
  output logic             irq_o,
  output logic             sleep_o
);
  logic     tick;
  logic     done;
  rx_char_t chr;

  mpr_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div_i(baud_div_i), .tick_o(tick)
  );

  mpr_shift #(.OVS(OVS)) u_shift (
    .clk(clk), .rst(rst), .tick_i(tick), .rx_i(rx_i),
    .par_en_i(par_en_i), .done_o(done), .chr_o(chr)
  );

  mpr_gate u_gate (
    .clk(clk), .rst(rst), .done_i(done), .chr_i(chr),
    .rx_en_i(rx_en_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .sleep_wr_i(sleep_wr_i), .sleep_val_i(sleep_val_i), .rd_i(rd_i),
    .data_o(data_o), .addr_o(addr_o), .rdy_o(rdy_o), .brk_o(brk_o),
    .fe_o(fe_o), .oe_o(oe_o), .pe_o(pe_o), .irq_o(irq_o), .sleep_o(sleep_o)
  );
endmodule

// File: tb/mp_uart_rx_test.sv
module mp_uart_rx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx = 1'b1;
  logic [15:0] div = 16'd0;
  logic        par_en = 1'b1;
  logic        par_odd = 1'b0;
  logic        rx_en = 1'b1;
  logic        sl_wr = 1'b0;
  logic        sl_val = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  data;
  logic        addr, rdy, brk, fe, oe, pe, irq, sleep;
  int          checks = 0;
  int          fails = 0;

  always #5 clk = ~clk;

  mp_uart_rx uut (
    .clk(clk), .rst(rst), .rx_i(rx), .baud_div_i(div),
    .par_en_i(par_en), .par_odd_i(par_odd), .rx_en_i(rx_en),
    .sleep_wr_i(sl_wr), .sleep_val_i(sl_val), .rd_i(rd),
    .data_o(data), .addr_o(addr), .rdy_o(rdy), .brk_o(brk), .fe_o(fe),
    .oe_o(oe), .pe_o(pe), .irq_o(irq), .sleep_o(sleep)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2: bit time is 16*(div+1) clocks
  task automatic send(input logic [7:0] d, input logic a, input logic pb,
                      input logic stopb, input int en_bit);
    int bt;
    int k;
    bt = 16 * (int'(div) + 1);
    k = 0;
    for (int i = 0; i < 12; i++) begin
      logic b;
      if (i == 0) b = 1'b0;
      else if (i <= 8) b = d[i-1];
      else if (i == 9 && par_en) b = pb;
      else if ((i == 9 && !par_en) || (i == 10 && par_en)) b = a;
      else if ((i == 10 && !par_en) || i == 11) b = stopb;
      else b = 1'b1;
      if (i == 11 && !par_en) break;
      if (k == en_bit) rx_en = 1'b1;
      rx = b;
      repeat (bt) @(negedge clk);
      k++;
    end
    rx = 1'b1;
    repeat (2 * bt) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic sleep_write(input logic v);
    sl_wr = 1'b1;
    sl_val = v;
    @(negedge clk);
    sl_wr = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic pbit(input logic [7:0] d);
    return ^d ^ par_odd;
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 reset rdy", rdy, 0);
    chk("R7 reset irq", irq, 0);
    chk("R7 reset data", data, 0);
    chk("R11 reset sleep", sleep, 0);

    // R1 R3 R7 R12: sweep of every data value, marker alternating, even parity
    for (int v = 0; v < 256; v++) begin
      send(8'(v), v[0], pbit(8'(v)), 1'b1, -1);
      chk("R1 data", data, v);
      chk("R1 addr", addr, v & 1);
      chk("R1 rdy", rdy, 1);
      chk("R3 no pe", pe, 0);
      chk("R12 irq", irq, 1);
      do_read();
      chk("R7 read clears rdy", rdy, 0);
    end

    // R3: odd parity
    par_odd = 1'b1;
    send(8'h5A, 1'b0, pbit(8'h5A), 1'b1, -1);
    chk("R3 odd good", pe, 0);
    do_read();
    send(8'h5A, 1'b0, ~pbit(8'h5A), 1'b1, -1);
    chk("R3 odd bad", pe, 1);
    do_read();
    chk("R7 pe cleared", pe, 0);
    par_odd = 1'b0;

    // R1: no parity bit in the frame
    par_en = 1'b0;
    send(8'h3C, 1'b1, 1'b0, 1'b1, -1);
    chk("R1 nopar data", data, 8'h3C);
    chk("R1 nopar addr", addr, 1);
    chk("R3 nopar pe", pe, 0);
    do_read();
    par_en = 1'b1;

    // R4: stop bit low
    send(8'h81, 1'b0, pbit(8'h81), 1'b0, -1);
    chk("R4 fe", fe, 1);
    chk("R5 no brk", brk, 0);
    do_read();
    chk("R7 fe cleared", fe, 0);

    // R5: break
    send(8'h00, 1'b0, 1'b0, 1'b0, -1);
    chk("R5 brk", brk, 1);
    chk("R4 brk fe", fe, 1);
    do_read();
    chk("R7 brk cleared", brk, 0);

    // R6: overrun
    send(8'h11, 1'b0, pbit(8'h11), 1'b1, -1);
    chk("R6 no oe first", oe, 0);
    send(8'h22, 1'b0, pbit(8'h22), 1'b1, -1);
    chk("R6 oe", oe, 1);
    chk("R6 newer data", data, 8'h22);
    do_read();
    chk("R7 oe cleared", oe, 0);

    // R2: slower divider
    div = 16'd1;
    send(8'hC3, 1'b1, pbit(8'hC3), 1'b1, -1);
    chk("R2 div1 data", data, 8'hC3);
    chk("R2 div1 rdy", rdy, 1);
    do_read();
    div = 16'd0;

    // R8: disabled
    rx_en = 1'b0;
    send(8'h77, 1'b0, pbit(8'h77), 1'b0, -1);
    chk("R8 rdy", rdy, 0);
    chk("R8 irq", irq, 0);
    chk("R8 data kept", data, 8'hC3);
    chk("R8 fe kept", fe, 0);

    // R9: enable rises mid character
    send(8'h99, 1'b0, pbit(8'h99), 1'b1, 4);
    chk("R9 rdy", rdy, 1);
    chk("R9 data", data, 8'h99);
    chk("R9 irq", irq, 1);
    do_read();

    // R12: irq follows enable
    send(8'h44, 1'b0, pbit(8'h44), 1'b1, -1);
    chk("R12 irq on", irq, 1);
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 irq off", irq, 0);
    chk("R12 rdy held", rdy, 1);
    rx_en = 1'b1;
    do_read();

    // R10 R11: sleep
    sleep_write(1'b1);
    chk("R11 sleep set", sleep, 1);
    send(8'h55, 1'b0, pbit(8'h55), 1'b0, -1);
    chk("R10 rdy", rdy, 0);
    chk("R10 fe", fe, 0);
    chk("R10 data kept", data, 8'h44);
    send(8'hA0, 1'b1, pbit(8'hA0), 1'b1, -1);
    chk("R11 addr rdy", rdy, 1);
    chk("R11 addr data", data, 8'hA0);
    chk("R11 addr bit", addr, 1);
    chk("R11 sleep kept", sleep, 1);
    do_read();
    sleep_write(1'b0);
    chk("R11 sleep cleared", sleep, 0);
    send(8'h12, 1'b0, pbit(8'h12), 1'b1, -1);
    chk("R10 awake data", data, 8'h12);
    chk("R10 awake rdy", rdy, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule